// File: doc/BRIEF.md
# One-Entry Searchable Pipeline Queue

This block is a single-slot queue placed between two pipeline stages. It holds one instruction template (an opaque payload) together with the register name that template will write and a flag saying whether it writes a register at all. The producing stage pushes templates in and the consuming stage reads the head and pops it. Two search ports let the producing stage ask, in the same cycle, whether either of two source register names is about to be written by the held template. The answer is used for stall decisions.

Within one clock cycle the operations behave as if they occur in this order: the head is read and popped, then the searches look at what remains, then a push lands, and finally a flush empties the queue. As a result, a full queue that is popped can accept a push in the same cycle. An entry leaving this cycle is never reported by a search. A flush wins over a push made in the same cycle.

The control is a two-state machine. Q_EMPTY means no entry is held and Q_HELD means one entry is held. The named transitions are: FILL (Q_EMPTY to Q_HELD on an accepted push without flush), REFILL (Q_HELD to Q_HELD on a pop and a push together), DRAIN (Q_HELD to Q_EMPTY on a pop with no push), FLUSH (any state to Q_EMPTY on flush), and STAY (no change otherwise).

Top module: `srch_pipe_q`

## Requirements
- R1: After reset, and during an asynchronous active-low reset, head_valid is 0 and push_ready is 1.
- R2: push_ready is 1 exactly when the queue is empty, or when it holds an entry and pop is 1 in the same cycle.
- R3: head_valid is 1 only while an entry is held. A pop while empty is ignored, and the queue stays empty.
- R4: A push made while push_ready is 0 is ignored: the held payload and destination are unchanged. push_err is 1 in that cycle and 0 in every other cycle.
- R5: An accepted push without flush makes head_valid 1 on the next cycle, with head_payload, head_dst and head_dst_vld equal to the pushed values.
- R6: A pop and a push together on a held entry replace it with the pushed entry on the next cycle. head_valid stays 1.
- R7: A pop without push on a held entry makes head_valid 0 on the next cycle.
- R8: qry_hit[i] is 1 in a cycle exactly when an entry is held, pop is 0, the entry's destination-valid flag is 1, and its destination equals key i, which is qry_key[i*REG_W +: REG_W].
- R9: A held entry pushed with push_dst_vld = 0 (a store or branch) never produces a hit, whatever the key.
- R10: flush makes head_valid 0 on the next cycle, even when a push is accepted in the same cycle.
- R11: The two search ports are independent: each compares its own key and may hit or miss regardless of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Push request |
| push_payload | input | PAYLOAD_W | Template to store |
| push_dst | input | REG_W | Register name the template writes |
| push_dst_vld | input | 1 | 1 when the template writes a register |
| push_ready | output | 1 | Push will be accepted this cycle |
| push_err | output | 1 | Push requested while not ready |
| pop | input | 1 | Remove the head entry |
| flush | input | 1 | Empty the queue, overriding a push |
| head_valid | output | 1 | An entry is held |
| head_payload | output | PAYLOAD_W | Held template |
| head_dst | output | REG_W | Held destination register name |
| head_dst_vld | output | 1 | Held destination-valid flag |
| qry_key | input | NUM_QRY*REG_W | Search keys, key i at bits i*REG_W upward |
| qry_hit | output | NUM_QRY | Per-key match result |

## Verification
A wrong state bit shows at the ports in the same cycle. head_valid, push_ready and both hit outputs are derived from it combinationally. For example, a queue that wrongly believes it is empty raises push_ready and drops every hit at once. A bad slot load shows up one cycle after the push, as a wrong head payload or a hit on the wrong key. A bad pop or flush ordering shows up in the cycle of the pop, when a hit on a leaving entry or a refused refill appears.

// File: rtl/sq_pkg.sv
package sq_pkg;
    typedef enum logic {
        Q_EMPTY = 1'b0,
        Q_HELD  = 1'b1
    } sq_state_e;
endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
    import sq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic push_valid,
    input  logic pop,
    input  logic flush,
    output logic held,
    output logic pop_take,
    output logic push_ready,
    output logic push_err,
    output logic load
);
    sq_state_e state_q;
    sq_state_e state_d;
    logic      push_take;

    // Outputs: pop ordered first, push sees the freed slot.
    always_comb begin
        held       = (state_q == Q_HELD);
        pop_take   = pop && (state_q == Q_HELD);
        push_ready = (state_q == Q_EMPTY) || pop_take;
        push_take  = push_valid && push_ready;
        push_err   = push_valid && !push_ready;
        load       = push_take && !flush;
    end

    // Transitions: FILL, REFILL, DRAIN, FLUSH, STAY.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: begin
                if (push_take && !flush) state_d = Q_HELD;          // FILL
            end
            Q_HELD: begin
                if (flush)                       state_d = Q_EMPTY; // FLUSH
                else if (pop_take && !push_take) state_d = Q_EMPTY; // DRAIN
                else                             state_d = Q_HELD;  // REFILL / STAY
            end
            default: state_d = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_d;
    end

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state_q == Q_EMPTY));

    a_r7_pop_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_HELD && pop && !push_valid && !flush) |=> (state_q == Q_EMPTY));

    a_r3_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_EMPTY && pop && !push_valid) |=> (state_q == Q_EMPTY));

    a_r6_refill_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_HELD && pop && push_valid && !flush) |=> (state_q == Q_HELD));
endmodule

// File: rtl/sq_slot.sv
module sq_slot #(
    parameter int PAYLOAD_W = 16,
    parameter int REG_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [PAYLOAD_W-1:0] in_payload,
    input  logic [REG_W-1:0]     in_dst,
    input  logic                 in_dst_vld,
    output logic [PAYLOAD_W-1:0] out_payload,
    output logic [REG_W-1:0]     out_dst,
    output logic                 out_dst_vld
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_payload <= '0;
            out_dst     <= '0;
            out_dst_vld <= 1'b0;
        end else if (load) begin
            out_payload <= in_payload;
            out_dst     <= in_dst;
            out_dst_vld <= in_dst_vld;
        end
    end
endmodule

// File: rtl/sq_match.sv
module sq_match #(
    parameter int REG_W = 5
) (
    input  logic             live,
    input  logic [REG_W-1:0] dst,
    input  logic             dst_vld,
    input  logic [REG_W-1:0] key,
    output logic             hit
);
    always_comb begin
        hit = live && dst_vld && (dst == key);
    end
endmodule

// File: rtl/srch_pipe_q.sv
module srch_pipe_q #(
    parameter int PAYLOAD_W = 16,
    parameter int REG_W     = 5,
    parameter int NUM_QRY   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_valid,
    input  logic [PAYLOAD_W-1:0]       push_payload,
    input  logic [REG_W-1:0]           push_dst,
    input  logic                       push_dst_vld,
    output logic                       push_ready,
    output logic                       push_err,
    input  logic                       pop,
    input  logic                       flush,
    output logic                       head_valid,
    output logic [PAYLOAD_W-1:0]       head_payload,
    output logic [REG_W-1:0]           head_dst,
    output logic                       head_dst_vld,
    input  logic [NUM_QRY*REG_W-1:0]   qry_key,
    output logic [NUM_QRY-1:0]         qry_hit
);
    logic pop_take;
    logic load;
    logic live;

    sq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .pop        (pop),
        .flush      (flush),
        .held       (head_valid),
        .pop_take   (pop_take),
        .push_ready (push_ready),
        .push_err   (push_err),
        .load       (load)
    );

    sq_slot #(.PAYLOAD_W(PAYLOAD_W), .REG_W(REG_W)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .in_payload  (push_payload),
        .in_dst      (push_dst),
        .in_dst_vld  (push_dst_vld),
        .out_payload (head_payload),
        .out_dst     (head_dst),
        .out_dst_vld (head_dst_vld)
    );

    // Search sees the queue after this cycle's pop, before the push.
    assign live = head_valid && !pop_take;

    for (genvar gi = 0; gi < NUM_QRY; gi++) begin : g_qry
        sq_match #(.REG_W(REG_W)) u_match (
            .live    (live),
            .dst     (head_dst),
            .dst_vld (head_dst_vld),
            .key     (qry_key[gi*REG_W +: REG_W]),
            .hit     (qry_hit[gi])
        );

        a_r8_hit_live: assert property (@(posedge clk) disable iff (!rst_n)
            qry_hit[gi] |-> (head_valid && !pop && head_dst == qry_key[gi*REG_W +: REG_W]));

        a_r9_no_dst_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
            !head_dst_vld |-> !qry_hit[gi]);
    end

    a_r5_fill_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ready && !flush) |=>
            (head_valid && head_payload == $past(push_payload) && head_dst == $past(push_dst)));

    a_r4_stall_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_ready && !flush) |=>
            (head_valid && $stable(head_payload) && $stable(head_dst)));
endmodule

// File: tb/srch_pipe_q_tb.sv
module srch_pipe_q_tb;
    localparam int PW = 16;
    localparam int RW = 5;
    localparam int NQ = 2;

    typedef struct packed {
        logic          pv;
        logic [PW-1:0] pd;
        logic [RW-1:0] dst;
        logic          dv;
        logic          pp;
        logic          fl;
        logic [RW-1:0] ka;
        logic [RW-1:0] kb;
        logic          rdy;
        logic          err;
        logic          ha;
        logic          hb;
        logic          hv;
        logic [PW-1:0] hd;
    } vec_t;

    localparam int NV = 18;
    // pv pd dst dv pop flush keyA keyB | ready err hitA hitB | valid payload (after edge)
    localparam vec_t VEC [NV] = '{
        '{1'b0,16'h0000,5'd0, 1'b0,1'b0,1'b0,5'd1, 5'd2,  1'b1,1'b0,1'b0,1'b0, 1'b0,16'h0000},
        '{1'b1,16'h00A1,5'd3, 1'b1,1'b0,1'b0,5'd3, 5'd3,  1'b1,1'b0,1'b0,1'b0, 1'b1,16'h00A1}, // R5 FILL
        '{1'b0,16'h0000,5'd0, 1'b0,1'b0,1'b0,5'd3, 5'd4,  1'b0,1'b0,1'b1,1'b0, 1'b1,16'h00A1}, // R8 R11
        '{1'b1,16'h00B2,5'd5, 1'b1,1'b0,1'b0,5'd4, 5'd3,  1'b0,1'b1,1'b0,1'b1, 1'b1,16'h00A1}, // R4 stall
        '{1'b1,16'h00C3,5'd7, 1'b1,1'b1,1'b0,5'd3, 5'd7,  1'b1,1'b0,1'b0,1'b0, 1'b1,16'h00C3}, // R6 R8
        '{1'b0,16'h0000,5'd0, 1'b0,1'b0,1'b0,5'd7, 5'd7,  1'b0,1'b0,1'b1,1'b1, 1'b1,16'h00C3},
        '{1'b0,16'h0000,5'd0, 1'b0,1'b1,1'b0,5'd7, 5'd0,  1'b1,1'b0,1'b0,1'b0, 1'b0,16'h0000}, // R7
        '{1'b0,16'h0000,5'd0, 1'b0,1'b1,1'b0,5'd0, 5'd0,  1'b1,1'b0,1'b0,1'b0, 1'b0,16'h0000}, // R3
        '{1'b1,16'h00D4,5'd9, 1'b0,1'b0,1'b0,5'd9, 5'd9,  1'b1,1'b0,1'b0,1'b0, 1'b1,16'h00D4},
        '{1'b0,16'h0000,5'd0, 1'b0,1'b0,1'b0,5'd9, 5'd0,  1'b0,1'b0,1'b0,1'b0, 1'b1,16'h00D4}, // R9
        '{1'b1,16'h00E5,5'd2, 1'b1,1'b1,1'b1,5'd2, 5'd9,  1'b1,1'b0,1'b0,1'b0, 1'b0,16'h0000}, // R10
        '{1'b1,16'h00F6,5'd0, 1'b1,1'b0,1'b0,5'd0, 5'd0,  1'b1,1'b0,1'b0,1'b0, 1'b1,16'h00F6},
        '{1'b0,16'h0000,5'd0, 1'b0,1'b0,1'b1,5'd0, 5'd0,  1'b0,1'b0,1'b1,1'b1, 1'b0,16'h0000}, // R10
        '{1'b1,16'h1234,5'd31,1'b1,1'b0,1'b0,5'd31,5'd30, 1'b1,1'b0,1'b0,1'b0, 1'b1,16'h1234},
        '{1'b0,16'h0000,5'd0, 1'b0,1'b0,1'b0,5'd30,5'd31, 1'b0,1'b0,1'b0,1'b1, 1'b1,16'h1234}, // R11
        '{1'b0,16'h0000,5'd0, 1'b0,1'b1,1'b0,5'd31,5'd31, 1'b1,1'b0,1'b0,1'b0, 1'b0,16'h0000},
        '{1'b1,16'h7777,5'd31,1'b1,1'b0,1'b1,5'd31,5'd31, 1'b1,1'b0,1'b0,1'b0, 1'b0,16'h0000}, // R10
        '{1'b0,16'h0000,5'd0, 1'b0,1'b0,1'b0,5'd31,5'd31, 1'b1,1'b0,1'b0,1'b0, 1'b0,16'h0000}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_valid = 1'b0;
    logic [PW-1:0]    push_payload = '0;
    logic [RW-1:0]    push_dst = '0;
    logic             push_dst_vld = 1'b0;
    logic             push_ready;
    logic             push_err;
    logic             pop = 1'b0;
    logic             flush = 1'b0;
    logic             head_valid;
    logic [PW-1:0]    head_payload;
    logic [RW-1:0]    head_dst;
    logic             head_dst_vld;
    logic [NQ*RW-1:0] qry_key = '0;
    logic [NQ-1:0]    qry_hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    srch_pipe_q #(.PAYLOAD_W(PW), .REG_W(RW), .NUM_QRY(NQ)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_valid   (push_valid),
        .push_payload (push_payload),
        .push_dst     (push_dst),
        .push_dst_vld (push_dst_vld),
        .push_ready   (push_ready),
        .push_err     (push_err),
        .pop          (pop),
        .flush        (flush),
        .head_valid   (head_valid),
        .head_payload (head_payload),
        .head_dst     (head_dst),
        .head_dst_vld (head_dst_vld),
        .qry_key      (qry_key),
        .qry_hit      (qry_hit)
    );

    task automatic chk(input string tag, input int idx, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s step %0d: actual %0h expected %0h", tag, idx, act, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 reset head_valid", -1, 32'(head_valid), 32'd0);
        chk("R1 reset push_ready", -1, 32'(push_ready), 32'd1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            push_valid   = VEC[i].pv;
            push_payload = VEC[i].pd;
            push_dst     = VEC[i].dst;
            push_dst_vld = VEC[i].dv;
            pop          = VEC[i].pp;
            flush        = VEC[i].fl;
            qry_key      = {VEC[i].kb, VEC[i].ka};
            #1;
            chk("R2 push_ready", i, 32'(push_ready), 32'(VEC[i].rdy));
            chk("R4 push_err", i, 32'(push_err), 32'(VEC[i].err));
            chk("R8 R9 R11 hit port 0", i, 32'(qry_hit[0]), 32'(VEC[i].ha));
            chk("R8 R9 R11 hit port 1", i, 32'(qry_hit[1]), 32'(VEC[i].hb));
            @(posedge clk);
            #2;
            chk("R3 R5 R7 R10 head_valid", i, 32'(head_valid), 32'(VEC[i].hv));
            if (VEC[i].hv)
                chk("R5 R6 head_payload", i, 32'(head_payload), 32'(VEC[i].hd));
        end

        // Directed: R5 destination fields, then R1 asynchronous reset mid-run.
        @(negedge clk);
        push_valid = 1'b1; push_payload = 16'hBEEF; push_dst = 5'd12; push_dst_vld = 1'b1;
        pop = 1'b0; flush = 1'b0; qry_key = '0;
        @(posedge clk);
        #2;
        chk("R5 head_dst", 100, 32'(head_dst), 32'd12);
        chk("R5 head_dst_vld", 100, 32'(head_dst_vld), 32'd1);
        @(negedge clk);
        push_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R1 async reset head_valid", 101, 32'(head_valid), 32'd0);
        chk("R1 async reset push_ready", 101, 32'(push_ready), 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        qry_key = {5'd12, 5'd12};
        #1;
        chk("R8 no hit after reset", 102, 32'(qry_hit), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule